// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which operating mode a processor is in and turns that decision into a set of enables. From run, a sleep strobe from the core enters one of two low-power states. A standby-select bit picks which one. Sleep stops only the CPU clock. Software standby also stops the peripheral clocks and the oscillator, and it parks the I/O ports either holding their last values or at high impedance.

Sleep is left only through a reset: the power-on reset pin, the manual reset pin, or a reset request from the watchdog. Software standby is left on a wake interrupt. The oscillator is then re-enabled and a settling count runs before the CPU clock returns. A low level on the hardware-standby pin overrides everything.

Every exit through reset holds the core for a minimum number of cycles with the reset pins released. The block then issues a single reset-exception start pulse. All inputs are taken as synchronous to `clk_i`.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low and just after its release, the mode is power-on reset. Mode code 3'b100, all clock enables low except `osc_en_o`, ports high impedance, `rst_start_o` low.
- R2: In run, a sleep strobe with `stby_sel_i`=0 gives sleep mode (code 3'b001) on the next cycle: CPU clock off, peripheral clock and oscillator on, ports driven. A wake interrupt has no effect in sleep, and neither does a sleep strobe outside run.
- R3: In run, a sleep strobe with `stby_sel_i`=1 gives software standby (code 3'b010) on the next cycle, with CPU clock, peripheral clock and oscillator all off.
- R4: `port_mode_o` is 2'b00 for driven, 2'b01 for hold-last-value and 2'b10 for high impedance. In software standby it is 2'b10 if `port_hiz_sel_i` was 1 at the sleep strobe, otherwise 2'b01. In run and sleep it is 2'b00.
- R5: From run or sleep, a low `ext_rst_ni` or a high `wdt_por_req_i` gives power-on reset on the next cycle. A low `ext_rst_ni` does so from every mode except hardware standby.
- R6: With `ext_rst_ni` high, a low `ext_mrst_ni` or a high `wdt_mrst_req_i` in run or sleep gives manual reset (code 3'b101, oscillator on, ports driven). A low `ext_mrst_ni` also does so from software standby. Watchdog requests have no effect in software standby.
- R7: A low `hw_stby_ni` gives hardware standby (code 3'b011) on the next cycle from any mode. It takes priority over every other input, and in it all enables are off and the ports are high impedance.
- R8: Power-on reset moves to run after RST_MIN (default 20) consecutive clock edges with `ext_rst_ni` high. Manual reset needs the same number of edges with both reset pins high. A pin low in between restarts the count.
- R9: `rst_start_o` is high for exactly one cycle: the first run cycle after power-on or manual reset.
- R10: In software standby, a wake interrupt starts a settling phase in which the mode code stays 3'b010 and only `osc_en_o` is on. Run follows after SETTLE_CYC (default 64) edges.
- R11: When `hw_stby_ni` returns high, the mode becomes power-on reset, and the R8 count applies before run.
- R12: `mode_o` only takes the codes 3'b000 (run), 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| sleep_req_i | input | 1 | Sleep-instruction strobe from the core |
| stby_sel_i | input | 1 | Standby-select control bit |
| port_hiz_sel_i | input | 1 | Port high-impedance select bit for software standby |
| ext_rst_ni | input | 1 | Power-on reset pin, active low |
| ext_mrst_ni | input | 1 | Manual reset pin, active low |
| hw_stby_ni | input | 1 | Hardware-standby pin, active low |
| wdt_por_req_i | input | 1 | Watchdog power-on reset request |
| wdt_mrst_req_i | input | 1 | Watchdog manual reset request |
| wake_irq_i | input | 1 | Wake interrupt for software standby |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| port_mode_o | output | 2 | Port output mode (00 driven, 01 hold, 10 high impedance) |
| rst_start_o | output | 1 | One-cycle reset-exception start pulse |
| mode_o | output | 3 | Current mode code |

## Verification
Directed sequences cover four cases:
- The two sleep-strobe variants, which separate the gating of sleep from that of standby.
- Both settings of the high-impedance bit, which separate hold from float.
- Reset pulses shorter than the minimum period, which separate a restarting count from one that only pauses.
- A hardware-standby edge that coincides with a sleep strobe, which shows the priority order.

A seeded random phase then mixes rare reset, watchdog and standby events with frequent strobes and wake interrupts. This reaches orderings the directed cases miss, such as a manual reset during settling or a watchdog request while in standby. Every cycle of that phase is compared with a bench model built from the requirements.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'b000,
    ST_SLEEP  = 3'b001,
    ST_SSTBY  = 3'b010,
    ST_HSTBY  = 3'b011,
    ST_POR    = 3'b100,
    ST_MRST   = 3'b101,
    ST_SETTLE = 3'b110   // internal, reported as ST_SSTBY
  } pmc_state_e;

  localparam logic [1:0] PORT_DRIVE = 2'b00;
  localparam logic [1:0] PORT_HOLD  = 2'b01;
  localparam logic [1:0] PORT_HIZ   = 2'b10;
endpackage

// File: rtl/pwr_wait_cnt.sv
module pwr_wait_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int RST_MIN    = 20,
  parameter int SETTLE_CYC = 64,
  parameter int CNT_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             stby_sel_i,
  input  logic             port_hiz_sel_i,
  input  logic             ext_rst_ni,
  input  logic             ext_mrst_ni,
  input  logic             hw_stby_ni,
  input  logic             wdt_por_req_i,
  input  logic             wdt_mrst_req_i,
  input  logic             wake_irq_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output pmc_state_e       state_o,
  output logic             hiz_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] RST_LAST    = CNT_W'(RST_MIN - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  pmc_state_e state_q, state_d;
  logic       hiz_q, cap_hiz, start_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    cap_hiz   = 1'b0;
    start_d   = 1'b0;
    if (!hw_stby_ni) begin
      state_d   = ST_HSTBY;
      cnt_clr_o = 1'b1;
    end else if (state_q == ST_HSTBY || !ext_rst_ni) begin
      state_d   = ST_POR;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN, ST_SLEEP: begin
          if (wdt_por_req_i) begin
            state_d   = ST_POR;
            cnt_clr_o = 1'b1;
          end else if (!ext_mrst_ni || wdt_mrst_req_i) begin
            state_d   = ST_MRST;
            cnt_clr_o = 1'b1;
          end else if (state_q == ST_RUN && sleep_req_i) begin
            state_d = stby_sel_i ? ST_SSTBY : ST_SLEEP;
            cap_hiz = 1'b1;
          end
        end
        ST_SSTBY: begin
          if (!ext_mrst_ni) begin
            state_d   = ST_MRST;
            cnt_clr_o = 1'b1;
          end else if (wake_irq_i) begin
            state_d   = ST_SETTLE;
            cnt_clr_o = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (!ext_mrst_ni) begin
            state_d   = ST_MRST;
            cnt_clr_o = 1'b1;
          end else if (cnt_i == SETTLE_LAST) state_d = ST_RUN;
          else cnt_inc_o = 1'b1;
        end
        ST_POR: begin
          if (cnt_i == RST_LAST) begin
            state_d = ST_RUN;
            start_d = 1'b1;
          end else cnt_inc_o = 1'b1;
        end
        ST_MRST: begin
          if (!ext_mrst_ni) cnt_clr_o = 1'b1;
          else if (cnt_i == RST_LAST) begin
            state_d = ST_RUN;
            start_d = 1'b1;
          end else cnt_inc_o = 1'b1;
        end
        default: begin
          state_d   = ST_POR;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POR;
      hiz_q   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      state_q <= state_d;
      start_o <= start_d;
      if (cap_hiz) hiz_q <= port_hiz_sel_i;
    end
  end

  assign state_o = state_q;
  assign hiz_o   = hiz_q;
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_mode_pkg::*;
(
  input  pmc_state_e  state_i,
  input  logic        hiz_i,
  output logic        cpu_clk_en_o,
  output logic        per_clk_en_o,
  output logic        osc_en_o,
  output logic [1:0]  port_mode_o,
  output logic [2:0]  mode_o
);
  logic [1:0] stby_port;
  assign stby_port = hiz_i ? PORT_HIZ : PORT_HOLD;

  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    osc_en_o     = 1'b0;
    port_mode_o  = PORT_DRIVE;
    mode_o       = state_i;
    unique case (state_i)
      ST_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
        osc_en_o     = 1'b1;
      end
      ST_SLEEP: begin
        per_clk_en_o = 1'b1;
        osc_en_o     = 1'b1;
      end
      ST_SSTBY:  port_mode_o = stby_port;
      ST_SETTLE: begin
        osc_en_o    = 1'b1;
        port_mode_o = stby_port;
        mode_o      = ST_SSTBY;
      end
      ST_HSTBY:  port_mode_o = PORT_HIZ;
      ST_POR: begin
        osc_en_o    = 1'b1;
        port_mode_o = PORT_HIZ;
      end
      ST_MRST:   osc_en_o = 1'b1;
      default: begin
        port_mode_o = PORT_HIZ;
        mode_o      = ST_POR;
      end
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int RST_MIN    = 20,
  parameter int SETTLE_CYC = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       stby_sel_i,
  input  logic       port_hiz_sel_i,
  input  logic       ext_rst_ni,
  input  logic       ext_mrst_ni,
  input  logic       hw_stby_ni,
  input  logic       wdt_por_req_i,
  input  logic       wdt_mrst_req_i,
  input  logic       wake_irq_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_en_o,
  output logic [1:0] port_mode_o,
  output logic       rst_start_o,
  output logic [2:0] mode_o
);
  localparam int CNT_MAX = (RST_MIN > SETTLE_CYC) ? RST_MIN : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc, hiz;
  pmc_state_e       state;

  pwr_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  pwr_mode_fsm #(
    .RST_MIN   (RST_MIN),
    .SETTLE_CYC(SETTLE_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_req_i   (sleep_req_i),
    .stby_sel_i    (stby_sel_i),
    .port_hiz_sel_i(port_hiz_sel_i),
    .ext_rst_ni    (ext_rst_ni),
    .ext_mrst_ni   (ext_mrst_ni),
    .hw_stby_ni    (hw_stby_ni),
    .wdt_por_req_i (wdt_por_req_i),
    .wdt_mrst_req_i(wdt_mrst_req_i),
    .wake_irq_i    (wake_irq_i),
    .cnt_i         (cnt),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc),
    .state_o       (state),
    .hiz_o         (hiz),
    .start_o       (rst_start_o)
  );

  pwr_out_dec u_dec (
    .state_i     (state),
    .hiz_i       (hiz),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o),
    .osc_en_o    (osc_en_o),
    .port_mode_o (port_mode_o),
    .mode_o      (mode_o)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       stby_sel_i,
  input logic       ext_rst_ni,
  input logic       ext_mrst_ni,
  input logic       hw_stby_ni,
  input logic       wdt_por_req_i,
  input logic       wdt_mrst_req_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic [1:0] port_mode_o,
  input logic       rst_start_o,
  input logic [2:0] mode_o
);
  logic quiet;
  assign quiet = hw_stby_ni && ext_rst_ni && ext_mrst_ni && !wdt_por_req_i && !wdt_mrst_req_i;

  a_r7_hw_stby_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_stby_ni |=> mode_o == 3'b011);

  a_r2_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b000 && quiet && sleep_req_i && !stby_sel_i) |=> mode_o == 3'b001);

  a_r3_stby_gating: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'b010 |-> (!cpu_clk_en_o && !per_clk_en_o));

  a_r5_por_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'b000 || mode_o == 3'b001) && hw_stby_ni && !ext_rst_ni) |=> mode_o == 3'b100);

  a_r6_mrst_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'b000 || mode_o == 3'b001) && hw_stby_ni && ext_rst_ni && !wdt_por_req_i
     && !ext_mrst_ni) |=> mode_o == 3'b101);

  a_r9_start_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_start_o |-> mode_o == 3'b000);

  a_r9_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_start_o |=> !rst_start_o);

  a_r4_port_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_mode_o != 2'b11);

  a_r12_mode_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'b101);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_req_i   (sleep_req_i),
  .stby_sel_i    (stby_sel_i),
  .ext_rst_ni    (ext_rst_ni),
  .ext_mrst_ni   (ext_mrst_ni),
  .hw_stby_ni    (hw_stby_ni),
  .wdt_por_req_i (wdt_por_req_i),
  .wdt_mrst_req_i(wdt_mrst_req_i),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .per_clk_en_o  (per_clk_en_o),
  .port_mode_o   (port_mode_o),
  .rst_start_o   (rst_start_o),
  .mode_o        (mode_o)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int RST_MIN    = 20;
  localparam int SETTLE_CYC = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req = 0, stby_sel = 0, hiz_sel = 0, ext_rst_n = 1, ext_mrst_n = 1;
  logic hw_stby_n = 1, wdt_por = 0, wdt_mrst = 0, wake = 0;
  logic cpu_en, per_en, osc_en, rst_start;
  logic [1:0] port_mode;
  logic [2:0] mode;

  int n_chk = 0, n_fail = 0;
  // model: 0 run,1 sleep,2 sstby,3 hstby,4 por,5 mrst,6 settling
  int e_st = 4, e_cnt = 0;
  bit e_hiz = 0, e_start = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.RST_MIN(RST_MIN), .SETTLE_CYC(SETTLE_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .stby_sel_i(stby_sel),
    .port_hiz_sel_i(hiz_sel), .ext_rst_ni(ext_rst_n), .ext_mrst_ni(ext_mrst_n),
    .hw_stby_ni(hw_stby_n), .wdt_por_req_i(wdt_por), .wdt_mrst_req_i(wdt_mrst),
    .wake_irq_i(wake), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .port_mode_o(port_mode), .rst_start_o(rst_start), .mode_o(mode)
  );

  // {mode, cpu, per, osc, port, start}
  function automatic logic [8:0] exp_vec();
    logic [1:0] sp = e_hiz ? 2'b10 : 2'b01;
    logic [2:0] m = (e_st == 6) ? 3'd2 : 3'(e_st);
    case (e_st)
      0: return {m, 3'b111, 2'b00, e_start};
      1: return {m, 3'b011, 2'b00, e_start};
      2: return {m, 3'b000, sp, e_start};
      6: return {m, 3'b001, sp, e_start};
      3: return {m, 3'b000, 2'b10, e_start};
      4: return {m, 3'b001, 2'b10, e_start};
      default: return {m, 3'b001, 2'b00, e_start};
    endcase
  endfunction

  function automatic logic [8:0] act_vec();
    return {mode, cpu_en, per_en, osc_en, port_mode, rst_start};
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int n = e_st;
    bit clr = 0, inc = 0, st = 0;
    if (!hw_stby_n) begin n = 3; clr = 1; end
    else if (e_st == 3 || !ext_rst_n) begin n = 4; clr = 1; end
    else case (e_st)
      0, 1: if (wdt_por) begin n = 4; clr = 1; end
            else if (!ext_mrst_n || wdt_mrst) begin n = 5; clr = 1; end
            else if (e_st == 0 && sleep_req) begin n = stby_sel ? 2 : 1; e_hiz = hiz_sel; end
      2: if (!ext_mrst_n) begin n = 5; clr = 1; end
         else if (wake) begin n = 6; clr = 1; end
      6: if (!ext_mrst_n) begin n = 5; clr = 1; end
         else if (e_cnt == SETTLE_CYC - 1) n = 0; else inc = 1;
      4: if (e_cnt == RST_MIN - 1) begin n = 0; st = 1; end else inc = 1;
      default: if (!ext_mrst_n) clr = 1;
               else if (e_cnt == RST_MIN - 1) begin n = 0; st = 1; end else inc = 1;
    endcase
    e_st = n; e_start = st;
    if (clr) e_cnt = 0; else if (inc) e_cnt++;
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, act_vec(), exp_vec());
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 reset state", act_vec(), {3'b100, 3'b001, 2'b10, 1'b0});
    ticks("R8 por count", RST_MIN - 1);
    chk("R8 still in reset", act_vec(), {3'b100, 3'b001, 2'b10, 1'b0});
    tick("R9");
    chk("R9 start pulse", act_vec(), {3'b000, 3'b111, 2'b00, 1'b1});
    tick("R9 pulse ends");
    // sleep, wake ignored
    sleep_req = 1; stby_sel = 0; tick("R2 sleep entry");
    chk("R2 sleep gating", act_vec(), {3'b001, 3'b011, 2'b00, 1'b0});
    sleep_req = 0; wake = 1; ticks("R2 wake ignored", 3); wake = 0;
    sleep_req = 1; tick("R2 strobe ignored in sleep"); sleep_req = 0;
    wdt_por = 1; tick("R5 wdt por from sleep"); wdt_por = 0;
    chk("R5 por mode", act_vec(), {3'b100, 3'b001, 2'b10, 1'b0});
    ticks("R8", RST_MIN);
    // standby, hold
    sleep_req = 1; stby_sel = 1; hiz_sel = 0; tick("R3 standby entry");
    sleep_req = 0; hiz_sel = 1;
    chk("R4 hold ports", act_vec(), {3'b010, 3'b000, 2'b01, 1'b0});
    wdt_por = 1; wdt_mrst = 1; tick("R6 wdt ignored in standby"); wdt_por = 0; wdt_mrst = 0;
    wake = 1; tick("R10 settle start"); wake = 0;
    ticks("R10 settling", SETTLE_CYC - 1);
    chk("R10 still settling", act_vec(), {3'b010, 3'b001, 2'b01, 1'b0});
    tick("R10");
    chk("R10 back in run", act_vec(), {3'b000, 3'b111, 2'b00, 1'b0});
    // standby, high impedance, manual reset exit
    sleep_req = 1; hiz_sel = 1; tick("R4 hiz standby"); sleep_req = 0;
    chk("R4 hiz ports", act_vec(), {3'b010, 3'b000, 2'b10, 1'b0});
    ext_mrst_n = 0; ticks("R6 mrst pin", 3); ext_mrst_n = 1;
    chk("R6 mrst mode", act_vec(), {3'b101, 3'b001, 2'b00, 1'b0});
    ticks("R8 mrst count", RST_MIN);
    chk("R9 start after mrst", act_vec(), {3'b000, 3'b111, 2'b00, 1'b1});
    // short pulse restarts count
    ext_rst_n = 0; tick("R5 pin por"); ext_rst_n = 1;
    ticks("R8 partial", 10);
    ext_rst_n = 0; tick("R8 restart"); ext_rst_n = 1;
    ticks("R8", RST_MIN - 1);
    chk("R8 restarted count", act_vec(), {3'b100, 3'b001, 2'b10, 1'b0});
    tick("R8 done");
    // hw standby priority over strobe
    sleep_req = 1; stby_sel = 0; hw_stby_n = 0; tick("R7 hw standby"); sleep_req = 0;
    chk("R7 hw standby", act_vec(), {3'b011, 3'b000, 2'b10, 1'b0});
    hw_stby_n = 1; tick("R11 release");
    chk("R11 por after release", act_vec(), {3'b100, 3'b001, 2'b10, 1'b0});
    ticks("R11", RST_MIN);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      hw_stby_n  = ($urandom_range(0, 299) != 0);
      ext_rst_n  = ($urandom_range(0, 199) != 0);
      ext_mrst_n = ($urandom_range(0, 149) != 0);
      wdt_por    = ($urandom_range(0, 249) == 0);
      wdt_mrst   = ($urandom_range(0, 249) == 0);
      sleep_req  = ($urandom_range(0, 7) == 0);
      stby_sel   = 1'($urandom_range(0, 1));
      hiz_sel    = 1'($urandom_range(0, 1));
      wake       = ($urandom_range(0, 15) == 0);
      tick("R12 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule